// File: doc/BRIEF.md
# Sticky Interrupt Event Register with Read-Clear

This block is a 16-bit control and status word for the management section of a PHY. The low byte holds eight sticky event flags, each raised by a one-cycle strobe from the logic that watches the link. The receive-error flag is the exception: it follows a raw level and is raised only when that level goes from low to high. The high byte holds eight enable bits, one per flag, that software writes.

A read strobe returns the whole word at once and clears every flag in the same cycle. An event that arrives during that read cycle is kept, so no event is lost. A single interrupt pin is driven whenever an enabled flag is set. A separate polarity input picks whether the pin is active high or active low. Software that does not use the pin can poll the word, because disabled flags are still recorded.

Top module: `irq_stat_reg`

## Requirements
- R1: After a synchronous reset, all flags and enables are 0, `rd_data_o` is 0 and `irq_o` is at its inactive level (the inverse of `pol_i`).
- R2: A strobe on `evt_stb_i[n]` (n not 6) sets flag n at the next clock edge. Flag positions: 7 jabber, 6 receive error, 5 page received, 4 parallel-detect fault, 3 partner acknowledge, 2 link status change, 1 remote fault, 0 negotiation complete.
- R3: A flag stays set until a read, whatever its event input does afterwards.
- R4: A read strobe loads `rd_data_o` at the next edge with {enables[15:8], flags[7:0]} as they stood before that edge, and clears all flags at that edge.
- R5: An event present in the same cycle as a read leaves its flag set after the clear. That event does not appear in that read's data.
- R6: A write strobe loads the enables from `wr_data_i[15:8]`. `wr_data_i[7:0]` has no effect on the flags.
- R7: Flag 6 is set only on a low-to-high transition of `rx_err_lvl_i`. A level that stays high does not set it again after a read, and `evt_stb_i[6]` has no effect.
- R8: `irq_o` is registered and follows the OR of (flag AND enable) one cycle later. It is active high when `pol_i` = 1 and active low when `pol_i` = 0.
- R9: A flag whose enable is 0 does not drive `irq_o`, but it is still recorded and returned by a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_stb_i | input | 8 | One-cycle event strobes, one per flag (bit 6 unused) |
| rx_err_lvl_i | input | 1 | Raw receive-error level |
| rd_stb_i | input | 1 | Read strobe: capture word and clear flags |
| wr_stb_i | input | 1 | Write strobe for the enables |
| wr_data_i | input | 16 | Write data; bits 15:8 are the enables |
| pol_i | input | 1 | Interrupt polarity: 1 active high, 0 active low |
| rd_data_o | output | 16 | Last word returned by a read |
| irq_o | output | 1 | Interrupt pin |

## Verification
The assertions check on every cycle that flags only drop through a read, that read data equals the word before the read edge, that writes load the enables, that a quiet read leaves all flags clear, that a steady receive-error level is not re-flagged across a read, and that the pin follows the masked OR with the right polarity. Only the bench scenarios show the bit placement of each named event, that an event coinciding with a read survives in the next read, that low write bits cannot touch the flags, and that masked flags remain visible to polling.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned EVT_W_DEF   = 8;
  // flag positions inside the low byte
  localparam int unsigned IDX_ANEG    = 0;
  localparam int unsigned IDX_RFAULT  = 1;
  localparam int unsigned IDX_LINKCHG = 2;
  localparam int unsigned IDX_LPACK   = 3;
  localparam int unsigned IDX_PDFAULT = 4;
  localparam int unsigned IDX_PAGE    = 5;
  localparam int unsigned IDX_RXERR   = 6;
  localparam int unsigned IDX_JABBER  = 7;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o
);
  for (genvar g = 0; g < W; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk) begin
      if (rst)        flag_q <= 1'b0;
      else if (set_i[g]) flag_q <= 1'b1;     // set beats clear
      else if (clr_i) flag_q <= 1'b0;
    end
    assign stat_o[g] = flag_q;
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] en_o
);
  always_ff @(posedge clk) begin
    if (rst)       en_o <= '0;
    else if (wr_i) en_o <= din_i;
  end
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] en_i,
  input  logic         pol_i,
  output logic         irq_o
);
  logic any_hit;
  assign any_hit = |(stat_i & en_i);

  always_ff @(posedge clk) begin
    if (rst) irq_o <= ~pol_i;
    else     irq_o <= any_hit ^ ~pol_i;
  end
endmodule

// File: rtl/irq_stat_reg.sv
module irq_stat_reg #(
  parameter int unsigned EVT_W     = irq_pkg::EVT_W_DEF,
  parameter int unsigned RXERR_IDX = irq_pkg::IDX_RXERR,
  localparam int unsigned REG_W    = 2 * EVT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] evt_stb_i,
  input  logic             rx_err_lvl_i,
  input  logic             rd_stb_i,
  input  logic             wr_stb_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             pol_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             irq_o
);
  logic             rx_rise;
  logic [EVT_W-1:0] set_vec;
  logic [EVT_W-1:0] stat_q;
  logic [EVT_W-1:0] en_q;
  logic             unused_bits;

  assign unused_bits = ^{wr_data_i[EVT_W-1:0], evt_stb_i[RXERR_IDX]};

  irq_edge_det u_rx_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (rx_err_lvl_i),
    .rise_o (rx_rise)
  );

  for (genvar g = 0; g < EVT_W; g++) begin : g_set
    if (g == RXERR_IDX) begin : g_rx
      assign set_vec[g] = rx_rise;
    end else begin : g_stb
      assign set_vec[g] = evt_stb_i[g];
    end
  end

  irq_status_bank #(.W(EVT_W)) u_stat (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set_vec),
    .clr_i  (rd_stb_i),
    .stat_o (stat_q)
  );

  irq_enable_reg #(.W(EVT_W)) u_en (
    .clk   (clk),
    .rst   (rst),
    .wr_i  (wr_stb_i),
    .din_i (wr_data_i[REG_W-1:EVT_W]),
    .en_o  (en_q)
  );

  irq_pin_drv #(.W(EVT_W)) u_pin (
    .clk    (clk),
    .rst    (rst),
    .stat_i (stat_q),
    .en_i   (en_q),
    .pol_i  (pol_i),
    .irq_o  (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst)           rd_data_o <= '0;
    else if (rd_stb_i) rd_data_o <= {en_q, stat_q};
  end
endmodule

// File: rtl/irq_stat_reg_chk.sv
module irq_stat_reg_chk #(
  parameter int unsigned EVT_W     = 8,
  parameter int unsigned RXERR_IDX = 6,
  localparam int unsigned REG_W    = 2 * EVT_W
) (
  input logic             clk,
  input logic             rst,
  input logic [EVT_W-1:0] evt_stb_i,
  input logic             rx_err_lvl_i,
  input logic             rd_stb_i,
  input logic             wr_stb_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic             pol_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             irq_o,
  input logic [EVT_W-1:0] stat_q,
  input logic [EVT_W-1:0] en_q
);
  localparam logic [EVT_W-1:0] STB_MASK = ~(EVT_W'(1) << RXERR_IDX);

  a_r2_strobe_sets: assert property (@(posedge clk) disable iff (rst)
    ((evt_stb_i & STB_MASK) != '0) |=>
      ((stat_q & $past(evt_stb_i & STB_MASK)) == $past(evt_stb_i & STB_MASK)));

  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    !rd_stb_i |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  a_r4_read_data: assert property (@(posedge clk) disable iff (rst)
    rd_stb_i |=> (rd_data_o == {$past(en_q), $past(stat_q)}));

  a_r4_quiet_clear: assert property (@(posedge clk) disable iff (rst)
    (rd_stb_i && ((evt_stb_i & STB_MASK) == '0) && !rx_err_lvl_i) |=> (stat_q == '0));

  a_r6_enable_load: assert property (@(posedge clk) disable iff (rst)
    wr_stb_i |=> (en_q == $past(wr_data_i[REG_W-1:EVT_W])));

  a_r7_level_no_reflag: assert property (@(posedge clk) disable iff (rst)
    (rd_stb_i && rx_err_lvl_i && $past(rx_err_lvl_i) && !$past(rst)) |=> !stat_q[RXERR_IDX]);

  a_r8_pin_level: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == ((|$past(stat_q & en_q)) ^ !$past(pol_i))));
endmodule

bind irq_stat_reg irq_stat_reg_chk #(.EVT_W(EVT_W), .RXERR_IDX(RXERR_IDX)) u_chk (.*);

// File: tb/test_irq_stat_reg.sv
module test_irq_stat_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  evt_stb_i = '0;
  logic        rx_err_lvl_i = 1'b0;
  logic        rd_stb_i = 1'b0;
  logic        wr_stb_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic        pol_i = 1'b1;
  logic [15:0] rd_data_o;
  logic        irq_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_stat_reg i_irq_stat_reg (
    .clk(clk), .rst(rst), .evt_stb_i(evt_stb_i), .rx_err_lvl_i(rx_err_lvl_i),
    .rd_stb_i(rd_stb_i), .wr_stb_i(wr_stb_i), .wr_data_i(wr_data_i),
    .pol_i(pol_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pulse_evt(input logic [7:0] m);
    @(negedge clk) evt_stb_i = m;
    @(negedge clk) evt_stb_i = '0;
  endtask

  task automatic do_read(output logic [15:0] v);
    @(negedge clk) rd_stb_i = 1'b1;
    @(negedge clk) rd_stb_i = 1'b0;
    v = rd_data_o;
  endtask

  task automatic do_write(input logic [15:0] d);
    @(negedge clk) begin wr_stb_i = 1'b1; wr_data_i = d; end
    @(negedge clk) wr_stb_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk({15'd0, irq_o}, 16'd0, "R1 irq inactive after reset");
    chk(rd_data_o, 16'h0000, "R1 read data after reset");
    do_read(v);
    chk(v, 16'h0000, "R1 word after reset");
  endtask

  task automatic t_each_event();
    logic [15:0] v;
    for (int i = 0; i < 8; i++) begin
      if (i != 6) begin
        pulse_evt(8'(1 << i));
        do_read(v);
        chk(v, 16'(1 << i), "R2 single event position");
      end
    end
  endtask

  task automatic t_sticky();
    logic [15:0] v;
    pulse_evt(8'h80);
    repeat (5) @(negedge clk);
    pulse_evt(8'h02);
    do_read(v);
    chk(v, 16'h0082, "R3 flags held until read");
    do_read(v);
    chk(v, 16'h0000, "R4 flags cleared by read");
  endtask

  task automatic t_coincident();
    logic [15:0] v;
    pulse_evt(8'h10);
    @(negedge clk) begin rd_stb_i = 1'b1; evt_stb_i = 8'h01; end
    @(negedge clk) begin rd_stb_i = 1'b0; evt_stb_i = 8'h00; end
    v = rd_data_o;
    chk(v, 16'h0010, "R5 coincident event absent from read data");
    do_read(v);
    chk(v, 16'h0001, "R5 coincident event kept after clear");
  endtask

  task automatic t_write();
    logic [15:0] v;
    do_write(16'hA5FF);
    do_read(v);
    chk(v, 16'hA500, "R6 enables loaded, low write bits ignored");
    do_write(16'h0000);
    do_read(v);
    chk(v, 16'h0000, "R6 enables cleared by write");
  endtask

  task automatic t_rxerr();
    logic [15:0] v;
    pulse_evt(8'h40);
    do_read(v);
    chk(v, 16'h0000, "R7 strobe bit 6 ignored");
    @(negedge clk) rx_err_lvl_i = 1'b1;
    repeat (3) @(negedge clk);
    do_read(v);
    chk(v, 16'h0040, "R7 rising edge sets flag 6");
    repeat (3) @(negedge clk);
    do_read(v);
    chk(v, 16'h0000, "R7 steady high does not re-set");
    @(negedge clk) rx_err_lvl_i = 1'b0;
    @(negedge clk) rx_err_lvl_i = 1'b1;
    @(negedge clk) rx_err_lvl_i = 1'b0;
    do_read(v);
    chk(v, 16'h0040, "R7 second rising edge sets flag 6");
  endtask

  task automatic t_irq_pol();
    logic [15:0] v;
    pol_i = 1'b1;
    do_write(16'h0100);
    @(negedge clk);
    chk({15'd0, irq_o}, 16'd0, "R8 idle, active high");
    pulse_evt(8'h01);
    @(negedge clk);
    chk({15'd0, irq_o}, 16'd1, "R8 asserted active high");
    do_read(v);
    @(negedge clk);
    chk({15'd0, irq_o}, 16'd0, "R8 released after read");
    pol_i = 1'b0;
    @(negedge clk);
    chk({15'd0, irq_o}, 16'd1, "R8 idle, active low");
    pulse_evt(8'h01);
    @(negedge clk);
    chk({15'd0, irq_o}, 16'd0, "R8 asserted active low");
    do_read(v);
    pol_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_mask_poll();
    logic [15:0] v;
    pulse_evt(8'h08);
    @(negedge clk);
    chk({15'd0, irq_o}, 16'd0, "R9 masked flag leaves pin inactive");
    do_read(v);
    chk(v, 16'h0108, "R9 masked flag visible to polling");
    do_write(16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_each_event();
    t_sticky();
    t_coincident();
    t_write();
    t_rxerr();
    t_irq_pol();
    t_mask_poll();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule